// File: doc/BRIEF.md
# Alignment Access Checker

This block sits between a load/store unit and a byte-addressed memory that is 32 bits wide. It takes one access request at a time: an address, an access size (byte, halfword or word), a direction and write data. It turns that request into one or two word-aligned memory transactions, and returns the load data or an alignment fault. Byte order follows a control input, so the same memory image can be read little-endian or big-endian.

A 2-bit policy input decides what happens to a misaligned access. The access can have its low address bits forced down to the natural boundary. It can be refused with a fault and no memory traffic. Or it can be completed transparently, and then an operand that straddles a word boundary costs two memory beats. The memory port uses a plain request/acknowledge pair. The request and its fields stay stable until the acknowledge arrives, so wait states simply stretch the access.

Top module: `mem_align_unit`

## Requirements
- R1: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 is handled as word. An aligned load returns its operand zero-extended on `rsp_rdata`, with `rsp_done` high for one cycle. With a memory that acknowledges at once, that cycle comes two cycles after the accepting edge. `mem_addr` always has its two low bits at zero.
- R2: With `big_endian`=1 the operand byte at the lowest address is the most significant byte. With `big_endian`=0 it is the least significant byte, so memory byte address+k carries `req_wdata`/`rsp_rdata` bits [8k+7:8k].
- R3: With policy 2'b00 a misaligned halfword or word has its address rounded down to the next lower multiple of its size, and it completes in a single memory transaction with no fault.
- R4: With policy 2'b01 or 2'b11 a misaligned access gives `rsp_done` and `rsp_fault` together one cycle after acceptance, issues no memory transaction and leaves memory unchanged. Aligned accesses under these policies complete normally.
- R5: With policy 2'b10 a misaligned operand that fits inside one word completes in one memory transaction.
- R6: With policy 2'b10 a load that straddles two words reads the lower word first, then the word at address+4. It returns the merged operand with a single `rsp_done` pulse, three cycles after acceptance when the memory acknowledges at once.
- R7: With policy 2'b10 a write that straddles two words issues two writes, lower word first. Between them the byte enables cover exactly the operand bytes, and every other memory byte keeps its value.
- R8: Every write sets `mem_be` only for the operand's bytes, so any write leaves the bytes outside the operand unchanged.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after `rsp_done`. A `req_valid` raised in that interval is ignored and causes no memory transaction.
- R10: During and right after reset, `req_ready` is 1 and `mem_req`, `rsp_done` and `rsp_fault` are 0.
- R11: `mem_req`, `mem_addr`, `mem_we` and `mem_be` hold steady until `mem_ack`. Each cycle without an acknowledge adds one cycle to the response latency.
- R12: Byte accesses are never misaligned. They never fault and never take the truncate path under any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle; a valid request is taken on this edge |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Store operand, right-justified |
| align_mode | input | 2 | Misalignment policy |
| big_endian | input | 1 | Byte order select |
| mem_req | output | 1 | Memory transaction request |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte lane enables, lane i is address+i |
| mem_wdata | output | 32 | Memory write data, lane-aligned |
| mem_ack | input | 1 | Memory transaction complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Alignment fault, valid with rsp_done |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |

## Verification
A fault answers one cycle after the accepting edge. A completed access answers 1 + beats × (wait states + 1) cycles after it, where a beat is one memory transaction. The bench works out that figure for every access from the policy, the size and the address offset, and then counts falling edges from acceptance until `rsp_done`. The count must match the figure exactly. The load data, the fault flag, the number and addresses of the memory beats, and the whole memory image are all sampled on that same falling edge. One falling edge later the bench confirms that `rsp_done` has dropped, that exactly one pulse was seen, and that `req_ready` is back.

// File: rtl/mau_pkg.sv
package mau_pkg;

  localparam int WORD_B = 4;
  localparam int WIN_B  = 2 * WORD_B;
  localparam int DATA_W = 8 * WORD_B;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    POL_TRUNC = 2'b00,
    POL_FAULT = 2'b01,
    POL_SPLIT = 2'b10,
    POL_ALT   = 2'b11
  } align_pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LO   = 2'b01,
    ST_HI   = 2'b10,
    ST_RESP = 2'b11
  } mau_state_e;

  // operand length in bytes
  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // address bits that must be zero for a natural boundary
  function automatic logic [1:0] align_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic is_misaligned(input logic [1:0] off, input logic [1:0] sz);
    return (off & align_mask(sz)) != 2'b00;
  endfunction

  function automatic logic crosses_word(input logic [1:0] off, input logic [1:0] sz);
    return ({1'b0, off} + size_to_bytes(sz)) > 3'd4;
  endfunction

endpackage

// File: rtl/mau_policy.sv
module mau_policy
  import mau_pkg::*;
(
  input  logic [1:0] addr_off,
  input  logic [1:0] size,
  input  logic [1:0] mode,
  output logic [1:0] eff_off,
  output logic       fault,
  output logic       split
);

  logic mis;

  always_comb begin
    mis     = is_misaligned(addr_off, size);
    eff_off = addr_off;
    fault   = 1'b0;
    split   = 1'b0;
    case (mode)
      POL_TRUNC: eff_off = addr_off & ~align_mask(size);
      POL_SPLIT: split   = crosses_word(addr_off, size);
      default:   fault   = mis;
    endcase
  end

endmodule

// File: rtl/mau_wr_pack.sv
module mau_wr_pack
  import mau_pkg::*;
(
  input  logic [DATA_W-1:0]  wdata,
  input  logic [1:0]         eff_off,
  input  logic [1:0]         size,
  input  logic               big_endian,
  output logic [8*WIN_B-1:0] win_data,
  output logic [WIN_B-1:0]   win_be
);

  logic [2:0] nbytes;
  assign nbytes = size_to_bytes(size);

  for (genvar l = 0; l < WIN_B; l++) begin : g_lane
    logic [3:0] k;
    logic       hit;
    logic [1:0] src;
    always_comb begin
      k   = 4'(l) - {2'b00, eff_off};
      hit = (4'(l) >= {2'b00, eff_off}) && (k < {1'b0, nbytes});
      src = big_endian ? 2'({1'b0, nbytes} - 4'd1 - k) : k[1:0];
    end
    assign win_be[l]          = hit;
    assign win_data[8*l +: 8] = hit ? wdata[8*src +: 8] : 8'h00;
  end

endmodule

// File: rtl/mau_rd_merge.sv
module mau_rd_merge
  import mau_pkg::*;
(
  input  logic [8*WIN_B-1:0] win,
  input  logic [1:0]         eff_off,
  input  logic [1:0]         size,
  input  logic               big_endian,
  output logic [DATA_W-1:0]  rdata
);

  logic [2:0] nbytes;
  assign nbytes = size_to_bytes(size);

  for (genvar j = 0; j < WORD_B; j++) begin : g_byte
    logic       hit;
    logic [2:0] k;
    logic [2:0] lane;
    always_comb begin
      hit  = 3'(j) < nbytes;
      k    = big_endian ? (nbytes - 3'd1 - 3'(j)) : 3'(j);
      lane = {1'b0, eff_off} + k;
    end
    assign rdata[8*j +: 8] = hit ? win[8*lane +: 8] : 8'h00;
  end

endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        align_mode,
  input  logic              big_endian,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [31:0]       rsp_rdata
);

  localparam int WORD_AW = ADDR_W - 2;

  mau_state_e state;

  logic [WORD_AW-1:0] q_word;
  logic [1:0]         q_off;
  logic [1:0]         q_size;
  logic               q_we;
  logic [31:0]        q_wdata;
  logic               q_big;
  logic               q_split;
  logic               q_fault;
  logic [31:0]        lo_buf;
  logic [31:0]        hi_buf;

  logic [1:0]         pol_off;
  logic               pol_fault;
  logic               pol_split;
  logic [63:0]        win_data;
  logic [7:0]         win_be;
  logic [31:0]        merged;
  logic               in_hi;

  // named events for the checker
  logic acc_evt;
  logic acc_fault_evt;
  logic lo_beat_evt;
  logic split_active;

  mau_policy u_policy (
    .addr_off (req_addr[1:0]),
    .size     (req_size),
    .mode     (align_mode),
    .eff_off  (pol_off),
    .fault    (pol_fault),
    .split    (pol_split)
  );

  mau_wr_pack u_pack (
    .wdata      (q_wdata),
    .eff_off    (q_off),
    .size       (q_size),
    .big_endian (q_big),
    .win_data   (win_data),
    .win_be     (win_be)
  );

  mau_rd_merge u_merge (
    .win        ({hi_buf, lo_buf}),
    .eff_off    (q_off),
    .size       (q_size),
    .big_endian (q_big),
    .rdata      (merged)
  );

  assign req_ready     = (state == ST_IDLE);
  assign acc_evt       = req_ready && req_valid;
  assign acc_fault_evt = acc_evt && pol_fault;
  assign lo_beat_evt   = (state == ST_LO) && mem_ack;
  assign split_active  = q_split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_word  <= '0;
      q_off   <= '0;
      q_size  <= '0;
      q_we    <= 1'b0;
      q_wdata <= '0;
      q_big   <= 1'b0;
      q_split <= 1'b0;
      q_fault <= 1'b0;
      lo_buf  <= '0;
      hi_buf  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            q_word  <= req_addr[ADDR_W-1:2];
            q_off   <= pol_off;
            q_size  <= req_size;
            q_we    <= req_write;
            q_wdata <= req_wdata;
            q_big   <= big_endian;
            q_split <= pol_split;
            q_fault <= pol_fault;
            state   <= pol_fault ? ST_RESP : ST_LO;
          end
        end
        ST_LO: begin
          if (mem_ack) begin
            lo_buf <= mem_rdata;
            state  <= q_split ? ST_HI : ST_RESP;
          end
        end
        ST_HI: begin
          if (mem_ack) begin
            hi_buf <= mem_rdata;
            state  <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_hi     = (state == ST_HI);
    mem_req   = (state == ST_LO) || in_hi;
    mem_addr  = {(in_hi ? q_word + WORD_AW'(1) : q_word), 2'b00};
    mem_we    = mem_req && q_we;
    mem_be    = '0;
    mem_wdata = '0;
    if (mem_req) begin
      mem_be    = in_hi ? win_be[7:4]    : win_be[3:0];
      mem_wdata = in_hi ? win_data[63:32] : win_data[31:0];
    end
    rsp_done  = (state == ST_RESP);
    rsp_fault = rsp_done && q_fault;
    rsp_rdata = (rsp_done && !q_we && !q_fault) ? merged : '0;
  end

endmodule

// File: rtl/mau_checker.sv
module mau_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic              mem_ack,
  input logic              rsp_done,
  input logic              rsp_fault,
  input logic              acc_evt,
  input logic              acc_fault_evt,
  input logic              lo_beat_evt,
  input logic              split_active
);

  // R1
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R4
  fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault_evt |=> (rsp_done && rsp_fault && !mem_req));

  // R4
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_done);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R6
  split_next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_beat_evt && split_active) |=>
      (mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(4))));

  // R8
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'b0000));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !req_ready);

  // R11
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

endmodule

bind mem_align_unit mau_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_we        (mem_we),
  .mem_be        (mem_be),
  .mem_ack       (mem_ack),
  .rsp_done      (rsp_done),
  .rsp_fault     (rsp_fault),
  .acc_evt       (acc_evt),
  .acc_fault_evt (acc_fault_evt),
  .lo_beat_evt   (lo_beat_evt),
  .split_active  (split_active)
);

// File: tb/mem_align_unit_tb_top.sv
module mem_align_unit_tb_top;

  localparam int ADDR_W = 16;
  localparam int NVEC   = 22;

  typedef struct packed {
    logic [1:0]  md;
    logic        bg;
    logic [1:0]  sz;
    logic        wr;
    logic [5:0]  ad;
    logic [31:0] wd;
    logic        xf;
    logic [1:0]  xb;
    logic [3:0]  rq;
  } vec_t;

  // policy, big, size, write, addr, wdata, fault, beats, requirement
  localparam vec_t VEC_TAB [NVEC] = '{
    '{2'b00, 1'b0, 2'b10, 1'b0, 6'd4,  32'h0,        1'b0, 2'd1, 4'd1},  // R1 word
    '{2'b00, 1'b0, 2'b01, 1'b0, 6'd6,  32'h0,        1'b0, 2'd1, 4'd1},  // R1 half
    '{2'b00, 1'b0, 2'b00, 1'b0, 6'd7,  32'h0,        1'b0, 2'd1, 4'd12}, // R12 odd byte
    '{2'b01, 1'b1, 2'b10, 1'b0, 6'd8,  32'h0,        1'b0, 2'd1, 4'd2},  // R2
    '{2'b01, 1'b1, 2'b01, 1'b0, 6'd10, 32'h0,        1'b0, 2'd1, 4'd2},  // R2
    '{2'b00, 1'b0, 2'b10, 1'b0, 6'd13, 32'h0,        1'b0, 2'd1, 4'd3},  // R3
    '{2'b00, 1'b1, 2'b01, 1'b0, 6'd17, 32'h0,        1'b0, 2'd1, 4'd3},  // R3
    '{2'b01, 1'b0, 2'b10, 1'b1, 6'd21, 32'hDEADBEEF, 1'b1, 2'd0, 4'd4},  // R4 store refused
    '{2'b11, 1'b0, 2'b01, 1'b0, 6'd23, 32'h0,        1'b1, 2'd0, 4'd4},  // R4 code 11
    '{2'b01, 1'b0, 2'b00, 1'b1, 6'd25, 32'h0000005A, 1'b0, 2'd1, 4'd12}, // R12
    '{2'b10, 1'b0, 2'b01, 1'b0, 6'd29, 32'h0,        1'b0, 2'd1, 4'd5},  // R5
    '{2'b10, 1'b0, 2'b10, 1'b0, 6'd30, 32'h0,        1'b0, 2'd2, 4'd6},  // R6
    '{2'b10, 1'b1, 2'b10, 1'b0, 6'd35, 32'h0,        1'b0, 2'd2, 4'd6},  // R6 big
    '{2'b10, 1'b0, 2'b10, 1'b1, 6'd38, 32'hA1B2C3D4, 1'b0, 2'd2, 4'd7},  // R7
    '{2'b10, 1'b1, 2'b01, 1'b1, 6'd43, 32'h0000BEEF, 1'b0, 2'd2, 4'd7},  // R7 big
    '{2'b00, 1'b0, 2'b10, 1'b1, 6'd40, 32'h11223344, 1'b0, 2'd1, 4'd8},  // R8
    '{2'b10, 1'b1, 2'b10, 1'b1, 6'd49, 32'hCAFEF00D, 1'b0, 2'd2, 4'd7},  // R7
    '{2'b00, 1'b0, 2'b01, 1'b1, 6'd51, 32'h00007788, 1'b0, 2'd1, 4'd3},  // R3 store
    '{2'b10, 1'b0, 2'b01, 1'b0, 6'd43, 32'h0,        1'b0, 2'd2, 4'd6},  // R6 readback
    '{2'b11, 1'b0, 2'b10, 1'b0, 6'd12, 32'h0,        1'b0, 2'd1, 4'd4},  // R4 aligned ok
    '{2'b10, 1'b0, 2'b01, 1'b0, 6'd30, 32'h0,        1'b0, 2'd1, 4'd5},  // R5 edge fit
    '{2'b10, 1'b0, 2'b00, 1'b0, 6'd63, 32'h0,        1'b0, 2'd1, 4'd12}  // R12
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic              req_write;
  logic [31:0]       req_wdata;
  logic [1:0]        align_mode;
  logic              big_endian;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic              mem_ack;
  logic [31:0]       mem_rdata;
  logic              rsp_done;
  logic              rsp_fault;
  logic [31:0]       rsp_rdata;

  int tests = 0;
  int fails = 0;
  int ws_cfg = 0;

  logic [7:0] mb    [64];
  logic [7:0] ref_b [64];
  logic [5:0] beat_log [8];
  int         beat_cnt;
  int         done_cnt;
  int         wait_cnt;
  logic [5:0] ba;

  always #5 clk = ~clk;

  mem_align_unit #(.ADDR_W(ADDR_W)) dut_i (.*);

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  // memory model with programmable wait states
  assign ba        = {mem_addr[5:2], 2'b00};
  assign mem_ack   = mem_req && (wait_cnt == 0);
  assign mem_rdata = {mb[ba + 6'd3], mb[ba + 6'd2], mb[ba + 6'd1], mb[ba]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mb[i] <= init_byte(i);
      beat_cnt <= 0;
      done_cnt <= 0;
      wait_cnt <= 0;
    end else begin
      if (mem_req && mem_ack) begin
        beat_log[beat_cnt % 8] <= mem_addr[5:0];
        beat_cnt <= beat_cnt + 1;
        if (mem_we)
          for (int i = 0; i < 4; i++)
            if (mem_be[i]) mb[ba + 6'(i)] <= mem_wdata[8*i +: 8];
      end
      if (rsp_done) done_cnt <= done_cnt + 1;
      if (!mem_req || mem_ack) wait_cnt <= ws_cfg;
      else                     wait_cnt <= wait_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_access(input logic [1:0] md, input logic bg, input logic [1:0] sz,
                            input logic wr, input logic [5:0] ad, input logic [31:0] wd,
                            input logic xf, input logic [1:0] xb, input string rq,
                            input bit poke);
    int n, ea, lat, cyc, b0, d0, mism;
    logic [31:0] val;
    logic [5:0]  w0;
    n  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    ea = ad;
    if ((ad % n) != 0 && md == 2'b00) ea = ad - (ad % n);
    lat = xf ? 1 : 1 + xb * (ws_cfg + 1);
    val = '0;
    if (!xf)
      for (int k = 0; k < n; k++) begin
        if (wr) ref_b[(ea + k) % 64] = bg ? wd[8*(n-1-k) +: 8] : wd[8*k +: 8];
        else if (bg) val[8*(n-1-k) +: 8] = ref_b[(ea + k) % 64];
        else         val[8*k +: 8]       = ref_b[(ea + k) % 64];
      end
    w0 = 6'(ea & 60);
    b0 = beat_cnt;
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; align_mode = md; big_endian = bg; req_size = sz;
    req_write = wr; req_addr = ADDR_W'(ad); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (poke) begin
      // R9 request while busy must be dropped
      chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = '0; req_size = 2'b10;
      align_mode = 2'b10; req_wdata = 32'hFFFF_FFFF;
      repeat (2) begin @(negedge clk); cyc++; end
      req_valid = 1'b0;
    end
    while (!rsp_done && cyc < 64) begin @(negedge clk); cyc++; end
    chk(cyc == lat, rq, "latency", 64'(cyc), 64'(lat));
    chk(rsp_fault == xf, rq, "fault", 64'(rsp_fault), 64'(xf));
    if (!wr && !xf) chk(rsp_rdata == val, rq, "load data", 64'(rsp_rdata), 64'(val));
    chk(beat_cnt - b0 == int'(xb), rq, "beats", 64'(beat_cnt - b0), 64'(xb));
    if (xb >= 2'd1)
      chk(beat_log[b0 % 8] == w0, rq, "first beat addr", 64'(beat_log[b0 % 8]), 64'(w0));
    if (xb == 2'd2)
      chk(beat_log[(b0 + 1) % 8] == w0 + 6'd4, rq, "second beat addr",
          64'(beat_log[(b0 + 1) % 8]), 64'(w0 + 6'd4));
    mism = 0;
    for (int i = 0; i < 64; i++) if (mb[i] !== ref_b[i]) mism++;
    chk(mism == 0, rq, "memory image bytes differing", 64'(mism), 64'd0);
    @(negedge clk);
    chk(rsp_done == 1'b0 && done_cnt - d0 == 1, rq, "done pulses",
        64'(done_cnt - d0), 64'd1);
    chk(req_ready == 1'b1, rq, "ready after done", 64'(req_ready), 64'd1);
  endtask

  initial begin
    #2_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; align_mode = '0; big_endian = 1'b0;
    for (int i = 0; i < 64; i++) ref_b[i] = init_byte(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 state while reset is held
    chk(req_ready && !mem_req && !rsp_done && !rsp_fault, "R10", "during reset",
        {60'd0, req_ready, mem_req, rsp_done, rsp_fault}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_done && !rsp_fault, "R10", "after reset",
        {60'd0, req_ready, mem_req, rsp_done, rsp_fault}, 64'h8);

    for (int v = 0; v < NVEC; v++)
      run_access(VEC_TAB[v].md, VEC_TAB[v].bg, VEC_TAB[v].sz, VEC_TAB[v].wr,
                 VEC_TAB[v].ad, VEC_TAB[v].wd, VEC_TAB[v].xf, VEC_TAB[v].xb,
                 $sformatf("R%0d", VEC_TAB[v].rq), 1'b0);

    // R11 wait states stretch a straddling load; R9 poke during it
    ws_cfg = 2;
    run_access(2'b10, 1'b0, 2'b10, 1'b0, 6'd30, 32'h0, 1'b0, 2'd2, "R11", 1'b1);
    // R11 aligned store with one wait state
    ws_cfg = 1;
    run_access(2'b00, 1'b1, 2'b10, 1'b1, 6'd56, 32'h0BADF00D, 1'b0, 2'd1, "R11", 1'b0);
    // R4 a fault does not wait on memory
    run_access(2'b01, 1'b0, 2'b01, 1'b1, 6'd57, 32'h0000AAAA, 1'b1, 2'd0, "R4", 1'b0);
    // R7 straddling store with wait states, then R2 big-endian readback
    run_access(2'b10, 1'b0, 2'b10, 1'b1, 6'd59, 32'h01234567, 1'b0, 2'd2, "R7", 1'b0);
    ws_cfg = 0;
    run_access(2'b10, 1'b1, 2'b10, 1'b0, 6'd59, 32'h0, 1'b0, 2'd2, "R2", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule